// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for the management register set of one Ethernet PHY. A host writes a 32-bit management frame word. The block decodes three things from that word: the direction (read or write), a register address and 16 bits of write data. It then carries out the access one clock later. For a read, the block returns the selected register in the low half of the frame word. For a write, the frame word holds exactly what was written. Every frame write, of either direction, produces a one-cycle completion pulse.

Serial clocking of the management bus is not modelled, and neither is real negotiation. Negotiation is reported complete at once. The link status bits follow a synchronized link input. An interrupt source register records link transitions and clears itself when read. Beside it sits a host-written interrupt mask.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset the registers hold these values: control = 0x3000, status = 0x7809, advertisement = 0x01E1, interrupt source = 0, interrupt mask = 0. After reset, `frame_rdata` = 0 and `mgmt_done` = 0.
- R2: Register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001. Writes to these registers change nothing.
- R3: A write to register 0 with bit 15 clear stores (data AND 0x7980) in control. If bit 12 of that data is set, status bit 5 is also set. If bit 12 is clear, status is left as it was.
- R4: A write to register 0 with bit 15 set returns control, status, advertisement, source and mask to their R1 values. If the link is up at that time, the link-up effects of R11 are applied again one cycle later.
- R5: A write to register 4 stores (data AND 0x2D7F) OR 0x0080 in advertisement.
- R6: Reading register 29 returns the interrupt source in bits 7:0 and then clears the source to 0. A link event in the same cycle as the read is kept.
- R7: Register 30 holds the interrupt mask. A write keeps only data bits 7:0, and a read returns them with bits 15:8 zero.
- R8: In `frame_wdata`, bit 29 = 1 selects a read and bit 29 = 0 selects a write. Bits 27:18 give the register address and bits 15:0 give the write data. After a read, `frame_rdata[31:16]` equals the written bits 31:16 and bits 15:0 hold the register value. After a write, `frame_rdata` equals the written word.
- R9: Addresses 32 and above, and every address in 0..31 other than 0 to 6, 29 and 30, read as 0. Writes to them change nothing. Writes to status (1) and to the interrupt source (29) also change nothing.
- R10: `mgmt_done` is high for exactly the one cycle after each cycle in which `frame_wr` is high, and is low otherwise.
- R11: The link input passes through a two-stage synchronizer. A rising link sets status bits 2 and 5 and sets source bits 7 and 6. A falling link clears status bits 2 and 5 and sets source bit 4. Each takes effect within three cycles of the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_wr | input | 1 | Management frame write strobe |
| frame_wdata | input | 32 | Management frame word written by the host |
| link_in | input | 1 | Asynchronous link-state input |
| frame_rdata | output | 32 | Frame register contents after the last operation |
| mgmt_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state in this block shows up on the ports at the next read of the register concerned. The value returned on `frame_rdata[15:0]` one cycle after the read frame would then differ from the value the bench computes from the writes and link changes so far. A lost or doubled clear of the interrupt source shows on the following read of register 29. A stuck or late completion pulse shows in the cycle right after the frame strobe. A link transition that is missed or applied twice shows in status and source within three cycles, and is seen at the next read.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int PHY_DW = 16;

  localparam logic [15:0] CTL_INIT   = 16'h3000;
  localparam logic [15:0] STS_INIT   = 16'h7809;
  localparam logic [15:0] ADV_INIT   = 16'h01E1;
  localparam logic [15:0] CTL_KEEP   = 16'h7980;
  localparam logic [15:0] ADV_KEEP   = 16'h2D7F;
  localparam logic [15:0] ADV_FORCE  = 16'h0080;
  localparam logic [15:0] ID_WORD_A  = 16'h0007;
  localparam logic [15:0] ID_WORD_B  = 16'hC0D1;
  localparam logic [15:0] PEER_ABIL  = 16'h0F71;
  localparam logic [15:0] NEG_EXPAN  = 16'h0001;
  localparam logic [15:0] STS_LINKUP = 16'h0024;
  localparam logic [15:0] STS_NEGDONE = 16'h0020;
  localparam logic [7:0]  SRC_UP     = 8'hC0;
  localparam logic [7:0]  SRC_DOWN   = 8'h10;

  localparam logic [4:0] IDX_CTL  = 5'd0;
  localparam logic [4:0] IDX_STS  = 5'd1;
  localparam logic [4:0] IDX_IDA  = 5'd2;
  localparam logic [4:0] IDX_IDB  = 5'd3;
  localparam logic [4:0] IDX_ADV  = 5'd4;
  localparam logic [4:0] IDX_PEER = 5'd5;
  localparam logic [4:0] IDX_EXP  = 5'd6;
  localparam logic [4:0] IDX_SRC  = 5'd29;
  localparam logic [4:0] IDX_MASK = 5'd30;
endpackage

// File: rtl/phy_frame_codec.sv
module phy_frame_codec
  import phy_mgmt_pkg::*;
#(
  parameter int FRAME_W  = 32,
  parameter int OP_BIT   = 29,
  parameter int ADDR_LSB = 18,
  parameter int ADDR_W   = 10
) (
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [PHY_DW-1:0]  rd_val,
  output logic               is_read,
  output logic               in_range,
  output logic [4:0]         idx,
  output logic [PHY_DW-1:0]  wr_data,
  output logic [FRAME_W-1:0] frame_out
);
  logic [ADDR_W-1:0] addr;

  assign addr     = frame_in[ADDR_LSB +: ADDR_W];
  assign is_read  = frame_in[OP_BIT];
  assign idx      = addr[4:0];
  assign in_range = ~|addr[ADDR_W-1:5];
  assign wr_data  = frame_in[PHY_DW-1:0];
  assign frame_out = is_read ? {frame_in[FRAME_W-1:PHY_DW], rd_val} : frame_in;
endmodule

// File: rtl/phy_link_sync.sv
module phy_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_prev,
  input  logic link_async,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], link_async};
      prev  <= clr_prev ? 1'b0 : chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;

  a_r11_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_mgmt_pkg::*;
#(
  parameter int INT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              is_read,
  input  logic              in_range,
  input  logic [4:0]        idx,
  input  logic [PHY_DW-1:0] wr_data,
  input  logic              link_rise,
  input  logic              link_fall,
  output logic [PHY_DW-1:0] rd_val,
  output logic              soft_rst
);
  localparam logic [INT_W-1:0] UP_BITS   = SRC_UP[INT_W-1:0];
  localparam logic [INT_W-1:0] DOWN_BITS = SRC_DOWN[INT_W-1:0];

  logic [PHY_DW-1:0] ctl_q, sts_q, adv_q, ctl_n, sts_n, adv_n;
  logic [INT_W-1:0]  src_q, msk_q, src_n, msk_n;
  logic              wr_hit, rd_hit;

  assign wr_hit   = op_valid & ~is_read & in_range;
  assign rd_hit   = op_valid &  is_read & in_range;
  assign soft_rst = wr_hit & (idx == IDX_CTL) & wr_data[15];

  always_comb begin
    ctl_n = ctl_q;
    sts_n = sts_q;
    adv_n = adv_q;
    src_n = src_q;
    msk_n = msk_q;
    if (wr_hit && idx == IDX_CTL) begin
      ctl_n = wr_data & CTL_KEEP;
      if (wr_data[12]) sts_n = sts_n | STS_NEGDONE;
    end
    if (wr_hit && idx == IDX_ADV)  adv_n = (wr_data & ADV_KEEP) | ADV_FORCE;
    if (wr_hit && idx == IDX_MASK) msk_n = wr_data[INT_W-1:0];
    if (rd_hit && idx == IDX_SRC)  src_n = '0;
    if (link_rise) begin
      sts_n = sts_n | STS_LINKUP;
      src_n = src_n | UP_BITS;
    end
    if (link_fall) begin
      sts_n = sts_n & ~STS_LINKUP;
      src_n = src_n | DOWN_BITS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctl_q <= CTL_INIT;
      sts_q <= STS_INIT;
      adv_q <= ADV_INIT;
      src_q <= '0;
      msk_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      sts_q <= sts_n;
      adv_q <= adv_n;
      src_q <= src_n;
      msk_q <= msk_n;
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_range) begin
      case (idx)
        IDX_CTL:  rd_val = ctl_q;
        IDX_STS:  rd_val = sts_q;
        IDX_IDA:  rd_val = ID_WORD_A;
        IDX_IDB:  rd_val = ID_WORD_B;
        IDX_ADV:  rd_val = adv_q;
        IDX_PEER: rd_val = PEER_ABIL;
        IDX_EXP:  rd_val = NEG_EXPAN;
        IDX_SRC:  rd_val = {{(PHY_DW-INT_W){1'b0}}, src_q};
        IDX_MASK: rd_val = {{(PHY_DW-INT_W){1'b0}}, msk_q};
        default:  rd_val = '0;
      endcase
    end
  end

  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && idx == IDX_SRC && !link_rise && !link_fall) |=> (src_q == '0));
  a_r6_event_kept: assert property (@(posedge clk) disable iff (rst)
    (link_rise && !soft_rst) |=> ((src_q & UP_BITS) == UP_BITS));
  a_r11_link_up: assert property (@(posedge clk) disable iff (rst)
    (link_rise && !soft_rst) |=> (sts_q[2] && sts_q[5]));
  a_r11_link_down: assert property (@(posedge clk) disable iff (rst)
    (link_fall && !soft_rst) |=> (!sts_q[2] && !sts_q[5] && ((src_q & DOWN_BITS) == DOWN_BITS)));
  a_r4_soft_reset: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ctl_q == CTL_INIT && adv_q == ADV_INIT && msk_q == '0));
  a_r3_ctl_keep: assert property (@(posedge clk) disable iff (rst)
    (ctl_q & ~CTL_KEEP) == '0);
  a_r5_adv_force: assert property (@(posedge clk) disable iff (rst)
    adv_q[7]);
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
  import phy_mgmt_pkg::*;
#(
  parameter int OP_BIT      = 29,
  parameter int ADDR_LSB    = 18,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int INT_W       = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_wr,
  input  logic [31:0] frame_wdata,
  input  logic        link_in,
  output logic [31:0] frame_rdata,
  output logic        mgmt_done
);
  localparam int FRAME_W = 32;

  logic              is_read, in_range, soft_rst, link_rise, link_fall;
  logic [4:0]        idx;
  logic [PHY_DW-1:0] wr_data, rd_val;
  logic [FRAME_W-1:0] frame_next;

  phy_frame_codec #(
    .FRAME_W(FRAME_W), .OP_BIT(OP_BIT), .ADDR_LSB(ADDR_LSB), .ADDR_W(ADDR_W)
  ) u_codec (
    .frame_in(frame_wdata), .rd_val(rd_val), .is_read(is_read),
    .in_range(in_range), .idx(idx), .wr_data(wr_data), .frame_out(frame_next)
  );

  phy_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .clr_prev(soft_rst), .link_async(link_in),
    .rise(link_rise), .fall(link_fall)
  );

  phy_reg_bank #(.INT_W(INT_W)) u_bank (
    .clk(clk), .rst(rst), .op_valid(frame_wr), .is_read(is_read),
    .in_range(in_range), .idx(idx), .wr_data(wr_data),
    .link_rise(link_rise), .link_fall(link_fall),
    .rd_val(rd_val), .soft_rst(soft_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_rdata <= '0;
      mgmt_done   <= 1'b0;
    end else begin
      mgmt_done <= frame_wr;
      if (frame_wr) frame_rdata <= frame_next;
    end
  end

  a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
    frame_wr |=> mgmt_done);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !frame_wr |=> !mgmt_done);
  a_r8_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (frame_wr && frame_wdata[OP_BIT]) |=> (frame_rdata[31:16] == $past(frame_wdata[31:16])));
  a_r8_write_echo: assert property (@(posedge clk) disable iff (rst)
    (frame_wr && !frame_wdata[OP_BIT]) |=> (frame_rdata == $past(frame_wdata)));
endmodule

// File: tb/phy_mgmt_model_tb.sv
module phy_mgmt_model_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_wr = 1'b0;
  logic        link_in = 1'b0;
  logic [31:0] frame_wdata = '0;
  logic [31:0] frame_rdata;
  logic        mgmt_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  logic [15:0] m_ctl, m_sts, m_adv, rv;
  logic [7:0]  m_src, m_msk;

  phy_mgmt_model u_dut (
    .clk(clk), .rst(rst), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .link_in(link_in), .frame_rdata(frame_rdata), .mgmt_done(mgmt_done)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl = 16'h3000; m_sts = 16'h7809; m_adv = 16'h01E1;
    m_src = 8'h00;    m_msk = 8'h00;
  endtask

  function automatic logic [31:0] mk(bit rd, logic [9:0] a, logic [15:0] d);
    return {2'b10, rd, 1'b1, a, 2'b11, d};
  endfunction

  function automatic logic [15:0] exp_rd(logic [9:0] a);
    if (a > 10'd31) return 16'h0;
    case (a)
      10'd0:  return m_ctl;
      10'd1:  return m_sts;
      10'd2:  return 16'h0007;
      10'd3:  return 16'hC0D1;
      10'd4:  return m_adv;
      10'd5:  return 16'h0F71;
      10'd6:  return 16'h0001;
      10'd29: return {8'h00, m_src};
      10'd30: return {8'h00, m_msk};
      default: return 16'h0;
    endcase
  endfunction

  task automatic op(bit rd, logic [9:0] a, logic [15:0] d);
    logic [31:0] w;
    w = mk(rd, a, d);
    @(negedge clk);
    frame_wdata = w;
    frame_wr = 1'b1;
    @(negedge clk);
    frame_wr = 1'b0;
    chk("R10 done pulse", {31'b0, mgmt_done}, 32'd1);
    if (rd) chk("R8 upper bits kept", {16'b0, frame_rdata[31:16]}, {16'b0, w[31:16]});
    else    chk("R8 write echo", frame_rdata, w);
    rv = frame_rdata[15:0];
    @(negedge clk);
    chk("R10 pulse ends", {31'b0, mgmt_done}, 32'd0);
  endtask

  task automatic rd_chk(string req, logic [9:0] a);
    op(1'b1, a, 16'hBEEF);
    chk(req, {16'b0, rv}, {16'b0, exp_rd(a)});
    if (a == 10'd29) m_src = 8'h00;
  endtask

  task automatic wr(logic [9:0] a, logic [15:0] d);
    op(1'b0, a, d);
    if (a == 10'd0) begin
      if (d[15]) model_reset();
      else begin
        m_ctl = d & 16'h7980;
        if (d[12]) m_sts = m_sts | 16'h0020;
      end
    end else if (a == 10'd4) m_adv = (d & 16'h2D7F) | 16'h0080;
    else if (a == 10'd30) m_msk = d[7:0];
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 32; a++) rd_chk(req, 10'(a));
    rd_chk(req, 10'd32);
    rd_chk(req, 10'd517);
    rd_chk(req, 10'd1023);
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 frame reset", frame_rdata, 32'h0);
    chk("R1 done reset", {31'b0, mgmt_done}, 32'd0);
    sweep("R1 R2 R9 reset sweep");

    // R9 / R2: writes to read-only and unimplemented addresses
    wr(10'd1, 16'hFFFF);
    wr(10'd2, 16'h1234);
    wr(10'd5, 16'h0000);
    wr(10'd29, 16'h00FF);
    wr(10'd17, 16'hFFFF);
    wr(10'd40, 16'hFFFF);
    wr(10'd1023, 16'hFFFF);
    sweep("R9 ignored writes");

    // R3: control mask, negotiation bit
    wr(10'd0, 16'h0100);
    rd_chk("R3 ctl no bit12", 10'd0);
    rd_chk("R3 sts untouched", 10'd1);
    wr(10'd0, 16'h7FFF);
    rd_chk("R3 ctl masked", 10'd0);
    rd_chk("R3 sts neg done", 10'd1);

    // R5: advertisement
    foreach (m_ctl[i]) if (i < 4) begin
      logic [15:0] v;
      v = (i == 0) ? 16'hFFFF : (i == 1) ? 16'h0000 : (i == 2) ? 16'h1234 : 16'hD280;
      wr(10'd4, v);
      rd_chk("R5 adv", 10'd4);
    end

    // R7: mask
    wr(10'd30, 16'h1234); rd_chk("R7 mask", 10'd30);
    wr(10'd30, 16'hFFFF); rd_chk("R7 mask", 10'd30);
    wr(10'd30, 16'hA500); rd_chk("R7 mask", 10'd30);

    // R11 / R6: link up
    link_in = 1'b1;
    wait_cyc(5);
    m_sts = m_sts | 16'h0024;
    m_src = m_src | 8'hC0;
    rd_chk("R11 link up status", 10'd1);
    rd_chk("R6 R11 source up", 10'd29);
    rd_chk("R6 cleared after read", 10'd29);

    // link down
    link_in = 1'b0;
    wait_cyc(5);
    m_sts = m_sts & ~16'h0024;
    m_src = m_src | 8'h10;
    rd_chk("R11 link down status", 10'd1);
    rd_chk("R6 R11 source down", 10'd29);
    rd_chk("R6 cleared after read", 10'd29);

    // R4: soft reset with link down
    wr(10'd4, 16'h0000);
    wr(10'd30, 16'h00FF);
    wr(10'd0, 16'h8000);
    sweep("R4 soft reset link down");

    // R4: soft reset with link up re-applies link
    link_in = 1'b1;
    wait_cyc(5);
    m_sts = m_sts | 16'h0024;
    m_src = m_src | 8'hC0;
    rd_chk("R11 up before soft reset", 10'd29);
    wr(10'd30, 16'h0055);
    wr(10'd0, 16'h9FFF);
    wait_cyc(3);
    m_sts = m_sts | 16'h0024;
    m_src = m_src | 8'hC0;
    sweep("R4 soft reset link up");

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule